// File: doc/BRIEF.md
# Mode-Controlled GPIO Port

This block is an eight-pin general-purpose I/O port. Each pin has a stored data bit and a two-bit mode, and both are reached over a small register bus. The mode of a pin decides four things: who drives the pin (a peripheral or the data register), whether the pin is driven at all, whether its pull-up is on, and whether a data read returns the stored bit or the live pin level.

Software writes the mode word once to set up each pin. It then reads and writes the data register as the port. Pin levels pass through a two-flop synchroniser before they reach the read path. Bus read data is registered.

The port has two resets. Power-on reset clears the data bits and returns every pin to input with pull-up. Manual reset leaves both the data bits and the modes as they were. A hold input, used during sleep or standby, freezes the stored registers and leaves the pin drive unchanged.

Top module: `mgpio_port`

## Requirements
- R1: While `por_rst` is high at a clock edge, the data register is cleared to 0x00 and every pin mode becomes 2'b10. After release, a read of the mode word returns 0xAAAA, `pin_oe` is 0x00 and `pin_pu` is 0xFF.
- R2: A manual reset (`man_rst` high, `por_rst` low) keeps the data register and the mode word unchanged. A bus write presented in the same cycle is ignored.
- R3: A write to address 0x00 stores `bus_wdata[7:0]` in the data register whatever the pin modes are. Bit n belongs to pin n.
- R4: A pin in mode 2'b01 drives: its `pin_oe` bit is 1, its `pin_out` bit equals its stored data bit, and its `pin_pu` bit is 0.
- R5: A pin in mode 2'b10 or 2'b11 is not driven (`pin_oe` 0, `pin_out` 0). Its `pin_pu` bit is 1 in mode 2'b10 and 0 in mode 2'b11. Its bit in a data read is the synchronised pin level.
- R6: A pin in mode 2'b00 takes `pin_out` and `pin_oe` from `alt_out` and `alt_oe`, has `pin_pu` 0, and returns its stored data bit on a data read.
- R7: `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value until the next read. Bits above 7 of a data read are 0. A read of any address other than 0x00 or 0x02 returns 0.
- R8: While `hold_i` is high, bus writes to both registers are ignored and the pin drive stays as it was. Reads still work.
- R9: The mode word sits at address 0x02, is read back whole, and pin n uses bits 2n+1:2n of it.
- R10: A value written to the data register while a pin is an input does not reach the pin. It appears on `pin_out` once the pin is switched to mode 2'b01.
- R11: A change on `pin_in` reaches read data through two register stages. A read sampled at the first or second clock edge after the change returns the old level. A read at the third edge returns the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hold_i | input | 1 | Sleep/standby hold: freezes stored registers |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte address: 0x00 data, 0x02 mode word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Raw pin levels (asynchronous) |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| pin_out | output | 8 | Pad output value |
| pin_oe | output | 8 | Pad output enable |
| pin_pu | output | 8 | Pad pull-up enable |

## Verification
The bench targets these corner cases:
- Mixed-mode words, where each pin in the same read takes its bit from a different source. A wrong per-pin split or a misplaced mode field shows up as swapped bits.
- Data written while a pin is an input. This checks that the value stays off the pad but is stored and appears once the pin becomes an output. A design that gated the store by mode would lose it.
- The two resets. A manual reset that cleared the data register, or a power-on reset that left the modes alone, is caught at `pin_out`, at `pin_pu` and on readback.
- Hold and read timing. Writes made during hold must leave no trace. Read data must not move without a strobe. A pin change must appear at exactly the third read edge, so a missing or extra synchroniser stage is seen.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    localparam int unsigned PIN_COUNT = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned BUS_W     = 16;
    localparam int unsigned SYNC_LEN  = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h02;

    typedef enum logic [1:0] {
        PM_ALT      = 2'b00,
        PM_PUSH     = 2'b01,
        PM_IN_PU    = 2'b10,
        PM_IN_FLOAT = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic is_mapped(logic [ADDR_W-1:0] a);
        return (a == ADDR_DATA) || (a == ADDR_MODE);
    endfunction

    function automatic logic reads_live(pin_mode_e m);
        return (m == PM_IN_PU) || (m == PM_IN_FLOAT);
    endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int unsigned WIDTH  = mgpio_pkg::PIN_COUNT,
    parameter int unsigned STAGES = mgpio_pkg::SYNC_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
    import mgpio_pkg::*;
#(
    parameter int unsigned N_PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                man_rst,
    input  logic                hold_i,
    input  bus_req_t            req,
    output logic [N_PINS-1:0]   data_q,
    output logic [2*N_PINS-1:0] mode_q
);
    localparam int unsigned MODE_W = 2 * N_PINS;
    localparam logic [MODE_W-1:0] MODE_RST = {N_PINS{2'(PM_IN_PU)}};

    logic wr_ok;
    assign wr_ok = req.wr && !hold_i && !man_rst;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            data_q <= '0;
            mode_q <= MODE_RST;
        end else if (wr_ok) begin
            if (req.addr == ADDR_DATA) data_q <= req.wdata[N_PINS-1:0];
            if (req.addr == ADDR_MODE) mode_q <= req.wdata[MODE_W-1:0];
        end
    end

    AST_POR_CLEARS: assert property (@(posedge clk)
        por_rst |=> (data_q == '0 && mode_q == MODE_RST)); // R1

    AST_MANRST_KEEPS: assert property (@(posedge clk) disable iff (por_rst)
        man_rst |=> ($stable(data_q) && $stable(mode_q))); // R2

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (por_rst)
        hold_i |=> ($stable(data_q) && $stable(mode_q))); // R8

    AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (por_rst)
        (req.wr && !hold_i && !man_rst && req.addr == ADDR_DATA)
            |=> data_q == $past(req.wdata[N_PINS-1:0])); // R3
endmodule

// File: rtl/mgpio_pin_ctrl.sv
module mgpio_pin_ctrl
    import mgpio_pkg::*;
#(
    parameter int unsigned N_PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*N_PINS-1:0] mode_q,
    input  logic [N_PINS-1:0]   data_q,
    input  logic [N_PINS-1:0]   alt_out,
    input  logic [N_PINS-1:0]   alt_oe,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   pin_pu,
    output logic [N_PINS-1:0]   live_sel
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pin_mode_e m;
        logic p_out, p_oe, p_pu;

        assign m = pin_mode_e'(mode_q[2*i +: 2]);

        always_comb begin
            p_out = 1'b0;
            p_oe  = 1'b0;
            p_pu  = 1'b0;
            unique case (m)
                PM_ALT: begin
                    p_out = alt_out[i];
                    p_oe  = alt_oe[i];
                end
                PM_PUSH: begin
                    p_out = data_q[i];
                    p_oe  = 1'b1;
                end
                PM_IN_PU:    p_pu = 1'b1;
                PM_IN_FLOAT: p_pu = 1'b0;
                default:     p_pu = 1'b0;
            endcase
        end

        assign pin_out[i]  = p_out;
        assign pin_oe[i]   = p_oe;
        assign pin_pu[i]   = p_pu;
        assign live_sel[i] = reads_live(m);

        AST_ALT_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
            (mode_q[2*i +: 2] == 2'b00)
                |-> (pin_oe[i] == alt_oe[i] && pin_out[i] == alt_out[i])); // R6
    end

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & live_sel) == '0); // R5

    AST_PULLUP_ONLY_INPUT: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & ~live_sel) == '0); // R5
endmodule

// File: rtl/mgpio_rd_path.sv
module mgpio_rd_path
    import mgpio_pkg::*;
#(
    parameter int unsigned N_PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    input  logic [N_PINS-1:0]   data_q,
    input  logic [2*N_PINS-1:0] mode_q,
    input  logic [N_PINS-1:0]   pin_sync,
    input  logic [N_PINS-1:0]   live_sel,
    output logic [BUS_W-1:0]    rdata
);
    localparam int unsigned MODE_W = 2 * N_PINS;

    logic [N_PINS-1:0] port_view;
    logic [BUS_W-1:0]  rd_next;

    assign port_view = (pin_sync & live_sel) | (data_q & ~live_sel);

    always_comb begin
        rd_next = '0;
        if (req.addr == ADDR_DATA)      rd_next[N_PINS-1:0] = port_view;
        else if (req.addr == ADDR_MODE) rd_next[MODE_W-1:0] = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_next;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(rdata)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !is_mapped(req.addr)) |=> rdata == '0); // R7
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int unsigned N_PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                man_rst,
    input  logic                hold_i,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [N_PINS-1:0]   pin_in,
    input  logic [N_PINS-1:0]   alt_out,
    input  logic [N_PINS-1:0]   alt_oe,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   pin_pu
);
    bus_req_t            req;
    logic                any_rst;
    logic [N_PINS-1:0]   data_q;
    logic [2*N_PINS-1:0] mode_q;
    logic [N_PINS-1:0]   pin_sync;
    logic [N_PINS-1:0]   live_sel;

    assign req     = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};
    assign any_rst = por_rst | man_rst;

    mgpio_regs #(.N_PINS(N_PINS)) regs_i (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hold_i(hold_i),
        .req(req), .data_q(data_q), .mode_q(mode_q)
    );

    mgpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_LEN)) sync_i (
        .clk(clk), .rst(any_rst), .d(pin_in), .q(pin_sync)
    );

    mgpio_pin_ctrl #(.N_PINS(N_PINS)) ctrl_i (
        .clk(clk), .rst(por_rst), .mode_q(mode_q), .data_q(data_q),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .live_sel(live_sel)
    );

    mgpio_rd_path #(.N_PINS(N_PINS)) rd_i (
        .clk(clk), .rst(any_rst), .req(req), .data_q(data_q), .mode_q(mode_q),
        .pin_sync(pin_sync), .live_sel(live_sel), .rdata(bus_rdata)
    );

    AST_HOLD_DRIVE_STABLE: assert property (@(posedge clk) disable iff (por_rst)
        (hold_i && $stable(alt_out) && $stable(alt_oe))
            |=> ($stable(pin_oe) && $stable(pin_pu))); // R8
endmodule

// File: tb/mgpio_port_tb_top.sv
module mgpio_port_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1, man_rst = 1'b0, hold_i = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [7:0]  pin_out, pin_oe, pin_pu;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgpio_port dut_i (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hold_i(hold_i),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    typedef struct packed {
        logic [15:0] mode;
        logic [7:0]  data, pins, ao, aoe, rd, out, oe, pu;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h5555, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hA5, 8'hFF, 8'h00},
        '{16'hAAAA, 8'h3C, 8'h96, 8'h00, 8'h00, 8'h96, 8'h00, 8'h00, 8'hFF},
        '{16'hFFFF, 8'hFF, 8'h41, 8'h00, 8'h00, 8'h41, 8'h00, 8'h00, 8'h00},
        '{16'h0000, 8'h5A, 8'hFF, 8'hC3, 8'h0F, 8'h5A, 8'hC3, 8'h0F, 8'h00},
        '{16'hE4E4, 8'h33, 8'h44, 8'hFF, 8'h11, 8'h77, 8'h33, 8'h33, 8'h44},
        '{16'h1B1B, 8'hF0, 8'h0F, 8'hAA, 8'hFF, 8'hC3, 8'hC8, 8'hCC, 8'h22}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_rst = 1'b0;
        idle(3);

        // R1: power-on state
        chk("R1 oe", {8'h0, pin_oe}, 16'h0000);
        chk("R1 pu", {8'h0, pin_pu}, 16'h00FF);
        bus_read(8'h02, r); chk("R1 mode", r, 16'hAAAA);
        bus_read(8'h00, r); chk("R1 data read (pins low)", r, 16'h0000);
        bus_write(8'h02, 16'h5555);
        chk("R1 data cleared", {8'h0, pin_out}, 16'h0000);

        // Vector table walk: R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            bus_write(8'h02, VECS[i].mode);
            bus_write(8'h00, {8'h00, VECS[i].data});
            pin_in = VECS[i].pins; alt_out = VECS[i].ao; alt_oe = VECS[i].aoe;
            idle(4);
            bus_read(8'h00, r);  chk("R3/R5/R6 data read", r, {8'h0, VECS[i].rd});
            bus_read(8'h02, r);  chk("R9 mode read", r, VECS[i].mode);
            chk("R4/R6 pin_out", {8'h0, pin_out}, {8'h0, VECS[i].out});
            chk("R4/R5/R6 pin_oe", {8'h0, pin_oe}, {8'h0, VECS[i].oe});
            chk("R5 pin_pu", {8'h0, pin_pu}, {8'h0, VECS[i].pu});
        end
        alt_out = '0; alt_oe = '0;

        // R10: data written in input mode stays off the pad
        pin_in = 8'h00;
        bus_write(8'h02, 16'hAAAA);
        bus_write(8'h00, 16'h0081);
        idle(3);
        chk("R10 not driven", {pin_oe, pin_out}, 16'h0000);
        bus_read(8'h00, r); chk("R10 read shows pin", r, 16'h0000);
        bus_write(8'h02, 16'h5555);
        chk("R10 appears on output", {pin_oe, pin_out}, 16'hFF81);
        bus_read(8'h00, r); chk("R3 stored in input mode", r, 16'h0081);

        // R8: hold freezes registers, drive unchanged
        hold_i = 1'b1;
        bus_write(8'h00, 16'h0000);
        bus_write(8'h02, 16'h0000);
        chk("R8 drive unchanged", {pin_oe, pin_out}, 16'hFF81);
        bus_read(8'h00, r); chk("R8 read during hold", r, 16'h0081);
        hold_i = 1'b0;
        bus_read(8'h02, r); chk("R8 mode frozen", r, 16'h5555);

        // R2: manual reset keeps data and mode, ignores same-cycle write
        bus_write(8'h00, 16'h0069);
        man_rst = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 16'h0000;
        @(posedge clk); @(negedge clk);
        man_rst = 1'b0; bus_wr = 1'b0;
        chk("R2 pin_out kept", {pin_oe, pin_out}, 16'hFF69);
        bus_read(8'h02, r); chk("R2 mode kept", r, 16'h5555);
        bus_read(8'h00, r); chk("R2 data kept", r, 16'h0069);

        // R7: registered read, hold without strobe, unmapped address
        bus_addr = 8'h02; bus_rd = 1'b1;
        #1 chk("R7 not before edge", r, bus_rdata);
        @(posedge clk); @(negedge clk); bus_rd = 1'b0;
        chk("R7 loaded at edge", bus_rdata, 16'h5555);
        bus_addr = 8'h00; idle(3);
        chk("R7 holds without strobe", bus_rdata, 16'h5555);
        bus_read(8'h04, r); chk("R7 unmapped", r, 16'h0000);

        // R11: synchroniser depth
        bus_write(8'h02, 16'hFFFF);
        pin_in = 8'h00; idle(4);
        pin_in = 8'h5C; bus_rd = 1'b1; bus_addr = 8'h00;
        @(posedge clk); @(negedge clk);
        chk("R11 first edge old", bus_rdata, 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R11 second edge old", bus_rdata, 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R11 third edge new", bus_rdata, 16'h005C);
        bus_rd = 1'b0;

        // R1: power-on reset after use clears data and modes
        por_rst = 1'b1; @(posedge clk); @(negedge clk); por_rst = 1'b0;
        chk("R1 re-por pu", {pin_oe, pin_pu}, 16'h00FF);
        bus_write(8'h02, 16'h5555);
        chk("R1 re-por data", {8'h0, pin_out}, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule